// File: doc/BRIEF.md
# Split Instruction/Data Relocation Unit

This unit sits on the path from a processor to memory and converts each user-level logical address into a physical one. It holds two independent region descriptors, each made of a base and a limit. One describes the code region and the other describes the data region. The processor marks every request as either an instruction fetch or a data access, and that mark picks the descriptor. The unit checks the logical address against the selected limit. It then adds the selected base to the logical address. The result is returned one cycle later together with a fault code.

The code descriptor is read-only by nature, which lets a code image be shared safely. Any write request marked as a fetch is trapped. The descriptors are programmed through a configuration port. That port only accepts writes while the supervisor input is high. A write attempted in user mode changes nothing and is reported on a one-cycle flag. After reset both limits are zero, so every access traps until software programs the descriptors.

Top module: `split_reloc_unit`

## Requirements
- R1: After reset both limits are zero. Any fetch or data read therefore returns fault code 2'b01 until a limit is programmed.
- R2: Each request cycle (reqValid high) produces rspValid high in the next cycle. A cycle without a request produces rspValid low in the next cycle. Requests may arrive on every cycle.
- R3: reqFetch=1 selects the code descriptor and reqFetch=0 selects the data descriptor. On a clean access, rspAddr equals the selected base plus the zero-extended logical address, truncated to PA_W bits.
- R4: An access is legal only if the logical address is strictly below the selected limit. An address equal to or above the limit returns fault code 2'b01.
- R5: A request with reqFetch=1 and reqWrite=1 returns fault code 2'b10. This takes priority over a limit violation.
- R6: Whenever rspFault is non-zero, rspAddr is zero.
- R7: A configuration write with cfgSupervisor high takes effect from the next cycle. A request in the same cycle as the write still uses the old value.
- R8: A configuration write with cfgSupervisor low leaves all descriptors unchanged. It raises cfgDenied for exactly the next cycle.
- R9: cfgSel selects the register to write: 0 is the code base, 1 is the code limit, 2 is the data base and 3 is the data limit. A limit takes only the low LA_W bits of cfgData.
- R10: While rspValid is low, rspFault is 2'b00 and rspAddr is zero. The fault code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSupervisor | input | 1 | High when the writer is privileged |
| cfgSel | input | 2 | Register select (see R9) |
| cfgData | input | PA_W | Value to write |
| cfgDenied | output | 1 | Pulses one cycle after a rejected user-mode write |
| reqValid | input | 1 | Request present |
| reqAddr | input | LA_W | Logical address |
| reqFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| rspValid | output | 1 | Response present |
| rspAddr | output | PA_W | Physical address, zero on fault |
| rspFault | output | 2 | 00 none, 01 limit violation, 10 write to code region |

## Verification
The assertions check the timing and encoding rules on every cycle. These are the one-cycle response latency, the code-write trap, the forced-zero address on a fault, the quiet idle response and the single-cycle denial pulse. The address arithmetic cannot be seen from the ports alone, so only the bench scenarios show it. The same holds for the strict limit boundary, the descriptor selection, the old-value rule for a write in the same cycle, and the fact that a user-mode write really leaves the descriptors untouched.

// File: rtl/split_reloc_pkg.sv
package split_reloc_pkg;
  localparam int NUM_PAIRS = 2;   // pair 0: code, pair 1: data
  localparam int CODE_PAIR = 0;
  localparam int DATA_PAIR = 1;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_LIMIT   = 2'b01,
    FLT_CODE_WR = 2'b10
  } fault_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [2*NUM_PAIRS-1:0] regWr;   // index = pair*2 + (0 base, 1 limit)
    logic                   selCode;
    logic                   rspLoad;
    fault_e                 fault;
  } reloc_strobe_t;
endpackage

// File: rtl/reloc_ctrl.sv
module reloc_ctrl
  import split_reloc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgSupervisor,
  input  logic [1:0]    cfgSel,
  input  logic          reqValid,
  input  logic          reqFetch,
  input  logic          reqWrite,
  input  logic          inLimit,
  output reloc_strobe_t strb,
  output logic          cfgDenied
);
  logic wrAllowed;
  logic wrRejected;

  assign wrAllowed  = cfgWrEn && cfgSupervisor;
  assign wrRejected = cfgWrEn && !cfgSupervisor;

  always_comb begin
    strb = '0;
    for (int i = 0; i < 2*NUM_PAIRS; i++) begin
      strb.regWr[i] = wrAllowed && (cfgSel == i[1:0]);
    end
    strb.selCode = reqFetch;
    strb.rspLoad = reqValid;
    if (reqFetch && reqWrite)  strb.fault = FLT_CODE_WR;
    else if (!inLimit)         strb.fault = FLT_LIMIT;
    else                       strb.fault = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgDenied <= 1'b0;
    else       cfgDenied <= wrRejected;
  end
endmodule

// File: rtl/reloc_datapath.sv
module reloc_datapath
  import split_reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  reloc_strobe_t   strb,
  input  logic [PA_W-1:0] cfgData,
  input  logic [LA_W-1:0] reqAddr,
  output logic            inLimit,
  output logic            rspValid,
  output logic [PA_W-1:0] rspAddr,
  output fault_e          rspFault
);
  localparam int EXT_W = PA_W - LA_W;

  logic [PA_W-1:0] baseReg [NUM_PAIRS];
  logic [LA_W-1:0] limReg  [NUM_PAIRS];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[p] <= '0;
        limReg[p]  <= '0;
      end else begin
        if (strb.regWr[2*p])   baseReg[p] <= cfgData;
        if (strb.regWr[2*p+1]) limReg[p]  <= cfgData[LA_W-1:0];
      end
    end
  end

  logic [PA_W-1:0] selBase;
  logic [LA_W-1:0] selLim;
  logic [PA_W-1:0] physAddr;

  assign selBase  = strb.selCode ? baseReg[CODE_PAIR] : baseReg[DATA_PAIR];
  assign selLim   = strb.selCode ? limReg[CODE_PAIR]  : limReg[DATA_PAIR];
  assign inLimit  = reqAddr < selLim;
  assign physAddr = selBase + {{EXT_W{1'b0}}, reqAddr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspFault <= FLT_NONE;
    end else begin
      rspValid <= strb.rspLoad;
      rspFault <= strb.rspLoad ? strb.fault : FLT_NONE;
      rspAddr  <= (strb.rspLoad && strb.fault == FLT_NONE) ? physAddr : '0;
    end
  end
endmodule

// File: rtl/split_reloc_unit.sv
module split_reloc_unit
  import split_reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic            cfgSupervisor,
  input  logic [1:0]      cfgSel,
  input  logic [PA_W-1:0] cfgData,
  output logic            cfgDenied,
  input  logic            reqValid,
  input  logic [LA_W-1:0] reqAddr,
  input  logic            reqFetch,
  input  logic            reqWrite,
  output logic            rspValid,
  output logic [PA_W-1:0] rspAddr,
  output logic [1:0]      rspFault
);
  reloc_strobe_t strb;
  logic          inLimit;
  fault_e        faultQ;

  reloc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSupervisor(cfgSupervisor), .cfgSel(cfgSel),
    .reqValid(reqValid), .reqFetch(reqFetch), .reqWrite(reqWrite),
    .inLimit(inLimit), .strb(strb), .cfgDenied(cfgDenied)
  );

  reloc_datapath #(.LA_W(LA_W), .PA_W(PA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgData(cfgData),
    .reqAddr(reqAddr), .inLimit(inLimit),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(faultQ)
  );

  assign rspFault = faultQ;
endmodule

// File: rtl/split_reloc_chk.sv
module split_reloc_chk #(
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgWrEn,
  input logic            cfgSupervisor,
  input logic            cfgDenied,
  input logic            reqValid,
  input logic            reqFetch,
  input logic            reqWrite,
  input logic            rspValid,
  input logic [PA_W-1:0] rspAddr,
  input logic [1:0]      rspFault
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_code_write_trap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFetch && reqWrite) |=> (rspFault == 2'b10));
  p_fault_zero_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault != 2'b00) |-> (rspAddr == '0));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspFault == 2'b00 && rspAddr == '0));
  p_no_code_11_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspFault != 2'b11);
  p_denied_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgSupervisor) |=> cfgDenied);
  p_denied_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && !cfgSupervisor) |=> !cfgDenied);
endmodule

bind split_reloc_unit split_reloc_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSupervisor(cfgSupervisor),
  .cfgDenied(cfgDenied), .reqValid(reqValid), .reqFetch(reqFetch),
  .reqWrite(reqWrite), .rspValid(rspValid), .rspAddr(rspAddr),
  .rspFault(rspFault)
);

// File: tb/split_reloc_unit_tb_top.sv
`timescale 1ns/1ps
module split_reloc_unit_tb_top;
  localparam int LA_W = 16;
  localparam int PA_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgSupervisor = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [PA_W-1:0] cfgData = '0;
  logic cfgDenied;
  logic reqValid = 1'b0, reqFetch = 1'b0, reqWrite = 1'b0;
  logic [LA_W-1:0] reqAddr = '0;
  logic rspValid;
  logic [PA_W-1:0] rspAddr;
  logic [1:0] rspFault;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  split_reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(bit sup, logic [1:0] sel, logic [PA_W-1:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSupervisor = sup; cfgSel = sel; cfgData = val;
    reqValid = 1'b0;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; cfgSupervisor = 1'b0;
  endtask

  // drive one request, keep valid high, check its response after the edge
  task automatic access(string tag, bit fetch, bit wr, logic [LA_W-1:0] la,
                        logic [1:0] expFault, logic [PA_W-1:0] expAddr);
    @(negedge clk);
    reqValid = 1'b1; reqFetch = fetch; reqWrite = wr; reqAddr = la;
    @(posedge clk); #1;
    check({tag, " valid"}, rspValid, 1);
    check({tag, " fault"}, rspFault, expFault);
    check({tag, " addr"}, rspAddr, expAddr);
  endtask

  task automatic idle();
    @(negedge clk); reqValid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R10 reset rspValid", rspValid, 0);
    check("R10 reset rspFault", rspFault, 0);
    check("R8 reset cfgDenied", cfgDenied, 0);
    access("R1 data read at 0", 0, 0, 16'h0000, 2'b01, 0);
    access("R1 fetch at 0", 1, 0, 16'h0000, 2'b01, 0);
    idle();
    check("R10 idle after reset", {rspValid, rspFault}, 0);
  endtask

  task automatic t_program();
    cfgWrite(1, 2'd0, 20'h10000);
    cfgWrite(1, 2'd1, 20'h00100);
    cfgWrite(1, 2'd2, 20'h40000);
    cfgWrite(1, 2'd3, 20'h02000);
  endtask

  task automatic t_translate();
    access("R3 fetch 0x40", 1, 0, 16'h0040, 2'b00, 20'h10040);
    access("R3 data read 0x40", 0, 0, 16'h0040, 2'b00, 20'h40040);
    access("R3 data write 0x1FFF", 0, 1, 16'h1FFF, 2'b00, 20'h41FFF);
    idle();
  endtask

  task automatic t_limits();
    access("R4 data at limit", 0, 0, 16'h2000, 2'b01, 0);
    access("R4 fetch below limit", 1, 0, 16'h00FF, 2'b00, 20'h100FF);
    access("R4 fetch at limit", 1, 0, 16'h0100, 2'b01, 0);
    access("R6 data far above limit", 0, 1, 16'hFFFF, 2'b01, 0);
    idle();
  endtask

  task automatic t_code_write();
    access("R5 fetch write in range", 1, 1, 16'h0010, 2'b10, 0);
    access("R5 fetch write over limit", 1, 1, 16'h0300, 2'b10, 0);
    idle();
  endtask

  task automatic t_user_write();
    cfgWrite(0, 2'd1, 20'h0FFFF);
    check("R8 denied pulse", cfgDenied, 1);
    @(posedge clk); #1;
    check("R8 denied clears", cfgDenied, 0);
    access("R8 code limit unchanged", 1, 0, 16'h0200, 2'b01, 0);
    access("R8 code base unchanged", 1, 0, 16'h0004, 2'b00, 20'h10004);
    idle();
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSupervisor = 1'b1; cfgSel = 2'd3; cfgData = 20'h00010;
    reqValid = 1'b1; reqFetch = 1'b0; reqWrite = 1'b0; reqAddr = 16'h0020;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; cfgSupervisor = 1'b0;
    check("R7 same-cycle uses old limit", rspFault, 2'b00);
    check("R7 same-cycle addr", rspAddr, 20'h40020);
    access("R7 new limit applies", 0, 0, 16'h0020, 2'b01, 0);
    idle();
  endtask

  task automatic t_limit_bits();
    cfgWrite(1, 2'd3, 20'h30010);
    access("R9 limit low bits below", 0, 0, 16'h000F, 2'b00, 20'h4000F);
    access("R9 limit low bits at", 0, 0, 16'h0010, 2'b01, 0);
    cfgWrite(1, 2'd2, 20'hFFFF8);
    access("R3 base wraps", 0, 0, 16'h000C, 2'b00, 20'h00004);
    idle();
  endtask

  task automatic t_back_to_back();
    access("R2 b2b fetch", 1, 0, 16'h0001, 2'b00, 20'h10001);
    access("R2 b2b data", 0, 0, 16'h0002, 2'b00, 20'hFFFFA);
    access("R2 b2b code write", 1, 1, 16'h0003, 2'b10, 0);
    access("R2 b2b fetch again", 1, 0, 16'h00FE, 2'b00, 20'h100FE);
    idle();
    check("R2 no request no response", rspValid, 0);
    check("R10 idle fault/addr", {rspFault, rspAddr}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    t_reset();
    t_program();
    t_translate();
    t_limits();
    t_code_write();
    t_user_write();
    t_same_cycle();
    t_limit_bits();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule